// File: doc/BRIEF.md
# Sequential Restoring Divider

This unit divides one word-sized operand by another over a fixed number of clock cycles, forming one quotient bit per cycle. It uses one trial subtractor and a double-width working register. The upper half of the register holds the partial remainder and the lower half starts out holding the dividend. The divisor is captured once and stays in place. On each step the working register moves one place left, the divisor is trial-subtracted from the upper half, and the difference is kept only when it is not negative. The outcome of that test enters the low end of the register as the next quotient bit, so the quotient fills the lower half as the dividend bits leave it.

A caller presents the operands together with a mode bit and pulses `start` while the unit is idle. The unit raises `busy`, steps through every bit of the word, then applies the sign correction and pulses `done`. The quotient and remainder stay on the outputs until the next operation completes. A zero divisor raises no exception. The operation runs for the usual number of cycles and returns a defined value.

Top module: `seqdiv_unit`

## Requirements
- R1: While reset is asserted and after it is released, `busy` and `done` are 0 and `quotient` and `remainder` are 0.
- R2: A `start` sampled high while `busy` is 0 is accepted on that edge. `busy` is 1 from the next cycle on. `done` rises exactly W+1 clock edges after the accepting edge, stays high for one cycle only, and `busy` falls on the same edge that `done` rises. `busy` and `done` are never high together.
- R3: A `start` sampled while `busy` is 1 has no effect. The running operation keeps its operands and its completion time.
- R4: With `signed_mode` = 0, the operands are unsigned. For a nonzero divisor, `quotient` is the floor of dividend/divisor and `remainder` is the dividend minus quotient×divisor, which is less than the divisor.
- R5: With `signed_mode` = 1, the operands are two's complement. The quotient is truncated toward zero, so it is negative exactly when the operand signs differ and the quotient magnitude is nonzero.
- R6: In signed mode, the remainder carries the sign of the dividend, its magnitude is less than the divisor magnitude, and quotient×divisor + remainder equals the dividend.
- R7: A zero divisor completes after the same number of cycles. In both modes it returns a quotient of all ones and a remainder equal to the dividend.
- R8: In signed mode, the most negative value divided by −1 returns quotient 0x80000000 (the most negative value) and remainder 0.
- R9: `quotient` and `remainder` change only on the edge that raises `done`. They hold the last result until the next operation completes.
- R10: `signed_mode` is sampled only on the accepting edge. Changing it during a run does not alter that run's result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins an operation when the unit is idle |
| signed_mode | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| dividend | input | W | Dividend operand, sampled at acceptance |
| divisor | input | W | Divisor operand, sampled at acceptance |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse when results are updated |
| quotient | output | W | Quotient (low half of the working register after correction) |
| remainder | output | W | Remainder (high half after correction) |

## Verification
The hardest cases to reach are those where the partial remainder comes close to the divisor, and the sign-fixup corner cases. Examples are a full-scale unsigned dividend, the most negative signed value over −1, and a zero divisor whose remainder path must pass the dividend back out unchanged. A vector table steers the stimulus onto each of these operand pairs directly. Directed runs then drive a second `start` and flip `signed_mode` mid-operation, at a point well inside the step window, to show that only the accepted operands decide the result and its timing.

// File: rtl/seqdiv_pkg.sv
package seqdiv_pkg;
   typedef enum logic [1:0] {
      DIV_IDLE = 2'd0,
      DIV_STEP = 2'd1,
      DIV_FIX  = 2'd2
   } div_state_e;
endpackage

// File: rtl/seqdiv_operand_prep.sv
module seqdiv_operand_prep #(
   parameter int W         = 32,
   parameter bit SIGNED_EN = 1'b1
) (
   input  logic         signed_mode,
   input  logic [W-1:0] dividend,
   input  logic [W-1:0] divisor,
   output logic [W-1:0] dvd_mag,
   output logic [W-1:0] dvs_mag,
   output logic         q_negate,
   output logic         r_negate,
   output logic         dvs_is_zero
);
   assign dvs_is_zero = (divisor == '0);

   generate
      if (SIGNED_EN) begin : g_signed
         logic dvd_neg, dvs_neg;
         assign dvd_neg  = signed_mode & dividend[W-1];
         assign dvs_neg  = signed_mode & divisor[W-1];
         assign dvd_mag  = dvd_neg ? (~dividend + W'(1)) : dividend;
         assign dvs_mag  = dvs_neg ? (~divisor + W'(1)) : divisor;
         assign q_negate = dvd_neg ^ dvs_neg;
         assign r_negate = dvd_neg;
      end else begin : g_unsigned
         logic unused_mode;
         assign unused_mode = signed_mode;
         assign dvd_mag  = dividend;
         assign dvs_mag  = divisor;
         assign q_negate = 1'b0;
         assign r_negate = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/seqdiv_datapath.sv
module seqdiv_datapath #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic         step,
   input  logic [W-1:0] dvd_mag,
   input  logic [W-1:0] dvs_mag,
   output logic [W-1:0] work_hi,
   output logic [W-1:0] work_lo
);
   logic [W-1:0] hi_q, lo_q, dvs_q;
   logic [W:0]   shifted_hi;
   logic [W:0]   trial;
   logic         fits;

   // shift left by one, then trial-subtract the fixed divisor from the upper half
   assign shifted_hi = {hi_q, lo_q[W-1]};
   assign trial      = shifted_hi - {1'b0, dvs_q};
   assign fits       = ~trial[W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_q  <= '0;
         lo_q  <= '0;
         dvs_q <= '0;
      end else if (load) begin
         hi_q  <= '0;
         lo_q  <= dvd_mag;
         dvs_q <= dvs_mag;
      end else if (step) begin
         // keep the difference, or restore the shifted value
         hi_q <= fits ? trial[W-1:0] : shifted_hi[W-1:0];
         lo_q <= {lo_q[W-2:0], fits};
      end
   end

   assign work_hi = hi_q;
   assign work_lo = lo_q;
endmodule

// File: rtl/seqdiv_ctrl.sv
module seqdiv_ctrl
   import seqdiv_pkg::*;
#(
   parameter int W = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy,
   output logic load,
   output logic step,
   output logic fix,
   output logic done
);
   localparam int CNT_W = $clog2(W);
   localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(W - 1);

   div_state_e       state_q, state_d;
   logic [CNT_W-1:0] cnt_q;

   assign busy = (state_q != DIV_IDLE);
   assign load = (state_q == DIV_IDLE) && start;
   assign step = (state_q == DIV_STEP);
   assign fix  = (state_q == DIV_FIX);

   always_comb begin
      state_d = state_q;
      case (state_q)
         DIV_IDLE: if (start) state_d = DIV_STEP;
         DIV_STEP: if (cnt_q == LAST_STEP) state_d = DIV_FIX;
         DIV_FIX:  state_d = DIV_IDLE;
         default:  state_d = DIV_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= DIV_IDLE;
         cnt_q   <= '0;
         done    <= 1'b0;
      end else begin
         state_q <= state_d;
         done    <= fix;
         if (load)      cnt_q <= '0;
         else if (step) cnt_q <= cnt_q + CNT_W'(1);
      end
   end
endmodule

// File: rtl/seqdiv_result_fix.sv
module seqdiv_result_fix #(
   parameter int W = 32
) (
   input  logic [W-1:0] work_hi,
   input  logic [W-1:0] work_lo,
   input  logic         q_negate,
   input  logic         r_negate,
   input  logic         dvs_is_zero,
   output logic [W-1:0] quo_fixed,
   output logic [W-1:0] rem_fixed
);
   always_comb begin
      if (dvs_is_zero)   quo_fixed = '1;
      else if (q_negate) quo_fixed = ~work_lo + W'(1);
      else               quo_fixed = work_lo;
      rem_fixed = r_negate ? (~work_hi + W'(1)) : work_hi;
   end
endmodule

// File: rtl/seqdiv_unit.sv
module seqdiv_unit #(
   parameter int W         = 32,
   parameter bit SIGNED_EN = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic         signed_mode,
   input  logic [W-1:0] dividend,
   input  logic [W-1:0] divisor,
   output logic         busy,
   output logic         done,
   output logic [W-1:0] quotient,
   output logic [W-1:0] remainder
);
   generate
      if (W < 4) begin : g_width_chk
         $error("seqdiv_unit: W must be at least 4");
      end
   endgenerate

   logic         load, step, fix;
   logic [W-1:0] dvd_mag, dvs_mag, work_hi, work_lo, quo_fixed, rem_fixed;
   logic         q_neg_in, r_neg_in, zero_in;
   logic         q_neg_q, r_neg_q, zero_q;

   seqdiv_ctrl #(.W(W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start),
      .busy(busy), .load(load), .step(step), .fix(fix), .done(done)
   );

   seqdiv_operand_prep #(.W(W), .SIGNED_EN(SIGNED_EN)) u_prep (
      .signed_mode(signed_mode), .dividend(dividend), .divisor(divisor),
      .dvd_mag(dvd_mag), .dvs_mag(dvs_mag),
      .q_negate(q_neg_in), .r_negate(r_neg_in), .dvs_is_zero(zero_in)
   );

   seqdiv_datapath #(.W(W)) u_dp (
      .clk(clk), .rst_n(rst_n), .load(load), .step(step),
      .dvd_mag(dvd_mag), .dvs_mag(dvs_mag),
      .work_hi(work_hi), .work_lo(work_lo)
   );

   seqdiv_result_fix #(.W(W)) u_fix (
      .work_hi(work_hi), .work_lo(work_lo),
      .q_negate(q_neg_q), .r_negate(r_neg_q), .dvs_is_zero(zero_q),
      .quo_fixed(quo_fixed), .rem_fixed(rem_fixed)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_neg_q   <= 1'b0;
         r_neg_q   <= 1'b0;
         zero_q    <= 1'b0;
         quotient  <= '0;
         remainder <= '0;
      end else begin
         if (load) begin
            q_neg_q <= q_neg_in;
            r_neg_q <= r_neg_in;
            zero_q  <= zero_in;
         end
         if (fix) begin
            quotient  <= quo_fixed;
            remainder <= rem_fixed;
         end
      end
   end
endmodule

// File: rtl/seqdiv_checker.sv
module seqdiv_checker #(
   parameter int W = 32
) (
   input logic         clk,
   input logic         rst_n,
   input logic         start,
   input logic         signed_mode,
   input logic [W-1:0] dividend,
   input logic [W-1:0] divisor,
   input logic         busy,
   input logic         done,
   input logic [W-1:0] quotient,
   input logic [W-1:0] remainder
);
   logic [15:0]    lat_cnt;
   logic [W-1:0]   cap_dvd, cap_dvs;
   logic           cap_signed;
   logic [2*W-1:0] recon;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lat_cnt    <= '0;
         cap_dvd    <= '0;
         cap_dvs    <= '0;
         cap_signed <= 1'b0;
      end else if (start && !busy) begin
         lat_cnt    <= '0;
         cap_dvd    <= dividend;
         cap_dvs    <= divisor;
         cap_signed <= signed_mode;
      end else if (busy) begin
         lat_cnt <= lat_cnt + 16'd1;
      end
   end

   assign recon = ({{W{1'b0}}, quotient} * {{W{1'b0}}, cap_dvs}) + {{W{1'b0}}, remainder};

   assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);
   assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   assert_busy_done_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy && done));
   // R3: a start during a run does not restart the latency window
   assert_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (lat_cnt == 16'(W + 1)));
   assert_unsigned_result_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !cap_signed && cap_dvs != '0) |->
         (recon == {{W{1'b0}}, cap_dvd} && remainder < cap_dvs));
   assert_zero_divisor_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (done && cap_dvs == '0) |-> (quotient == '1 && remainder == cap_dvd));
   assert_hold_outputs_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(quotient) || !$stable(remainder)) |-> done);
endmodule

bind seqdiv_unit seqdiv_checker #(.W(W)) u_seqdiv_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .signed_mode(signed_mode),
   .dividend(dividend), .divisor(divisor), .busy(busy), .done(done),
   .quotient(quotient), .remainder(remainder)
);

// File: tb/seqdiv_unit_bench.sv
module seqdiv_unit_bench;
   localparam int W = 32;
   localparam int NV = 13;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic         signed_mode = 1'b0;
   logic [W-1:0] dividend = '0;
   logic [W-1:0] divisor = '0;
   logic         busy, done;
   logic [W-1:0] quotient, remainder;

   int checks = 0;
   int bad = 0;

   always #5 clk = ~clk;

   seqdiv_unit #(.W(W)) u_seqdiv_unit (
      .clk(clk), .rst_n(rst_n), .start(start), .signed_mode(signed_mode),
      .dividend(dividend), .divisor(divisor), .busy(busy), .done(done),
      .quotient(quotient), .remainder(remainder)
   );

   localparam logic          V_SGN [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0,
                                             1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1};
   localparam logic [W-1:0]  V_DVD [NV] = '{32'd100, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'd5,
                                             32'h8000_0000, 32'd12345, 32'hFFFF_FFF9,
                                             32'hFFFF_FFF9, 32'd7, 32'hFFFF_FFF9,
                                             32'h8000_0000, 32'hFFFF_FFFB, 32'd100};
   localparam logic [W-1:0]  V_DVS [NV] = '{32'd7, 32'd1, 32'hFFFF_FFFF, 32'd9, 32'd3,
                                             32'd0, 32'd2, 32'd2, 32'hFFFF_FFFE,
                                             32'hFFFF_FFFE, 32'hFFFF_FFFF, 32'd0, 32'd7};
   localparam logic [W-1:0]  V_Q   [NV] = '{32'd14, 32'hFFFF_FFFF, 32'd1, 32'd0,
                                             32'h2AAA_AAAA, 32'hFFFF_FFFF, 32'h7FFF_FFFC,
                                             32'hFFFF_FFFD, 32'hFFFF_FFFD, 32'd3,
                                             32'h8000_0000, 32'hFFFF_FFFF, 32'd14};
   localparam logic [W-1:0]  V_R   [NV] = '{32'd2, 32'd0, 32'd0, 32'd5, 32'd2, 32'd12345,
                                             32'd1, 32'hFFFF_FFFF, 32'd1, 32'hFFFF_FFFF,
                                             32'd0, 32'hFFFF_FFFB, 32'd2};
   localparam string         V_TAG [NV] = '{"R4", "R4", "R4", "R4", "R4", "R7", "R4",
                                             "R5", "R6", "R6", "R8", "R7", "R5"};

   task automatic check(input string tag, input string what,
                        input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic run_op(input logic sm, input logic [W-1:0] a, input logic [W-1:0] b,
                         output logic [W-1:0] q, output logic [W-1:0] r, output int cyc);
      @(negedge clk);
      start = 1'b1; signed_mode = sm; dividend = a; divisor = b;
      @(negedge clk);
      start = 1'b0;
      cyc = 0;
      while (!done && cyc < 100) begin
         @(negedge clk);
         cyc++;
      end
      q = quotient;
      r = remainder;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      bad++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end

   initial begin
      logic [W-1:0] q, r;
      int cyc;

      // R1: reset state
      repeat (3) @(negedge clk);
      check("R1", "busy in reset", W'(busy), '0);
      check("R1", "done in reset", W'(done), '0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", "busy after reset", W'(busy), '0);
      check("R1", "quotient after reset", quotient, '0);
      check("R1", "remainder after reset", remainder, '0);

      // vector table: R4 R5 R6 R7 R8
      for (int i = 0; i < NV; i++) begin
         run_op(V_SGN[i], V_DVD[i], V_DVS[i], q, r, cyc);
         check(V_TAG[i], "quotient", q, V_Q[i]);
         check(V_TAG[i], "remainder", r, V_R[i]);
      end

      // R2: latency, pulse width, busy release
      run_op(1'b0, 32'd1000, 32'd33, q, r, cyc);
      check("R2", "done latency", W'(cyc), W'(W + 1));
      check("R2", "busy at done", W'(busy), '0);
      @(negedge clk);
      check("R2", "done one cycle", W'(done), '0);
      check("R4", "quotient 1000/33", q, 32'd30);

      // R9: outputs hold after completion
      repeat (5) @(negedge clk);
      check("R9", "quotient held", quotient, 32'd30);
      check("R9", "remainder held", remainder, 32'd10);

      // R7: zero divisor keeps normal latency
      run_op(1'b1, 32'h8000_0000, 32'd0, q, r, cyc);
      check("R7", "zero divisor latency", W'(cyc), W'(W + 1));
      check("R7", "zero divisor remainder", r, 32'h8000_0000);

      // R3 and R10: start and mode change mid-run are ignored
      @(negedge clk);
      start = 1'b1; signed_mode = 1'b0; dividend = 32'hFFFF_FFF0; divisor = 32'd10;
      @(negedge clk);
      start = 1'b0;
      cyc = 0;
      repeat (5) begin @(negedge clk); cyc++; end
      start = 1'b1; signed_mode = 1'b1; dividend = 32'd9; divisor = 32'd3;
      @(negedge clk); cyc++;
      start = 1'b0;
      while (!done && cyc < 100) begin @(negedge clk); cyc++; end
      check("R3", "latency with second start", W'(cyc), W'(W + 1));
      check("R3", "quotient from first operands", quotient, 32'h1999_9998);
      check("R10", "remainder in unsigned mode", remainder, 32'd0);
      @(negedge clk);
      check("R3", "no restart after done", W'(busy), '0);

      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end
endmodule